// File: doc/BRIEF.md
# Triggered Three-Cycle Pulse Timer

This block is a small synchronous Moore controller. It waits in an idle state until a single-bit trigger is seen high on a rising clock edge. It then drives its output high for exactly three clock cycles and returns to idle. The trigger is assumed to be synchronous to the clock already. Every state change happens on a rising edge.

The state is held in a two-bit register with a binary encoding. The output is the OR of the two state bits. Because the output comes from state alone, a trigger that is held or repeated while the pulse is running cannot lengthen it. The state register is also brought out as a debug port. A parameter selects between two forms of next-state logic: the reduced sum-of-products equations or a case statement. The two forms behave the same.

Top module: `pulse3_timer`

## Requirements
- R1: A synchronous active-high reset forces the state to idle (code 00) at the next rising edge, and the output is 0 from that edge on.
- R2: The debug port shows the state code: idle = 00, first high = 01, second high = 10, third high = 11.
- R3: In idle with the trigger low at a rising edge, the state stays idle.
- R4: In idle with the trigger high at a rising edge, the state moves to first high (01).
- R5: First high moves to second high, and second high moves to third high, on the next edge whatever the trigger is.
- R6: The output is 1 exactly when the state code is non-zero (bit 1 OR bit 0). It depends on the state only.
- R7: Each accepted trigger gives exactly three consecutive cycles with the output high. A trigger held or repeated during those cycles does not extend the pulse.
- R8: Third high always returns to idle on the next edge. A trigger that is still high then is only accepted on the edge after that, so two pulses are separated by at least one low cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Start request, already synchronous to clk |
| pulse_out | output | 1 | High during the three pulse states |
| state_dbg | output | STATE_W | Current state code, for debug |

## Verification
The in-design properties assume that trig and rst are stable around every rising edge and are never X once reset has been seen. They also assume that reset is held from time zero until at least one edge has passed. The bench keeps within these limits. It changes every input only on the falling edge and starts with reset asserted for several cycles. This lets each property start from a defined idle state. The stimulus includes held triggers, triggers repeated during a pulse, a long pseudo-random trigger pattern and a reset in the middle of a pulse. All of these are legal synchronous inputs.

// File: rtl/pulse3_pkg.sv
package pulse3_pkg;
   localparam int P3_STATE_W = 2;

   // Binary codes; the output decode relies on idle being all zeros.
   typedef enum logic [P3_STATE_W-1:0] {
      ST_IDLE = 2'b00,
      ST_HI1  = 2'b01,
      ST_HI2  = 2'b10,
      ST_HI3  = 2'b11
   } p3_state_e;
endpackage

// File: rtl/pulse3_next.sv
module pulse3_next
   import pulse3_pkg::*;
#(
   parameter bit USE_EQN = 1'b1
) (
   input  p3_state_e cur,
   input  logic      trig,
   output p3_state_e nxt
);
   generate
      if (USE_EQN) begin : g_eqn
         logic n1, n0;
         // Reduced equations for the four-state chain.
         assign n1  = cur[1] ^ cur[0];
         assign n0  = (~cur[1] & ~cur[0] & trig) | (cur[1] & ~cur[0]);
         assign nxt = p3_state_e'({n1, n0});
      end else begin : g_case
         always_comb begin
            case (cur)
               ST_IDLE: nxt = trig ? ST_HI1 : ST_IDLE;
               ST_HI1:  nxt = ST_HI2;
               ST_HI2:  nxt = ST_HI3;
               default: nxt = ST_IDLE;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/pulse3_sreg.sv
module pulse3_sreg
   import pulse3_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  p3_state_e nxt,
   output p3_state_e cur
);
   always_ff @(posedge clk) begin
      if (rst) cur <= ST_IDLE;
      else     cur <= nxt;
   end
endmodule

// File: rtl/pulse3_out.sv
module pulse3_out
   import pulse3_pkg::*;
(
   input  p3_state_e cur,
   output logic      level
);
   // Moore output: any non-idle code drives the pulse.
   assign level = cur[1] | cur[0];
endmodule

// File: rtl/pulse3_timer.sv
module pulse3_timer
   import pulse3_pkg::*;
#(
   parameter bit USE_EQN = 1'b1,
   parameter int STATE_W = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               trig,
   output logic               pulse_out,
   output logic [STATE_W-1:0] state_dbg
);
   localparam int ENC_W = $bits(p3_state_e);

   generate
      if (STATE_W != ENC_W) begin : g_bad_width
         $error("pulse3_timer: STATE_W must match the state encoding width");
      end
   endgenerate

   p3_state_e st_cur, st_nxt;

   pulse3_next #(.USE_EQN(USE_EQN)) u_next (
      .cur (st_cur),
      .trig(trig),
      .nxt (st_nxt)
   );

   pulse3_sreg u_sreg (
      .clk(clk),
      .rst(rst),
      .nxt(st_nxt),
      .cur(st_cur)
   );

   pulse3_out u_out (
      .cur  (st_cur),
      .level(pulse_out)
   );

   assign state_dbg = st_cur;

   // R1
   reset_idle_chk: assert property (@(posedge clk) rst |=> (state_dbg == 2'b00 && !pulse_out));
   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (state_dbg == 2'b00 && !trig) |=> (state_dbg == 2'b00));
   // R4
   accept_chk: assert property (@(posedge clk) disable iff (rst)
      (state_dbg == 2'b00 && trig) |=> (state_dbg == 2'b01 && pulse_out));
   // R5
   advance1_chk: assert property (@(posedge clk) disable iff (rst)
      (state_dbg == 2'b01) |=> (state_dbg == 2'b10 && pulse_out));
   // R5
   advance2_chk: assert property (@(posedge clk) disable iff (rst)
      (state_dbg == 2'b10) |=> (state_dbg == 2'b11 && pulse_out));
   // R8
   release_chk: assert property (@(posedge clk) disable iff (rst)
      (state_dbg == 2'b11) |=> (state_dbg == 2'b00 && !pulse_out));
   // R7
   no_extend_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(pulse_out) |-> (state_dbg == 2'b01));
endmodule

// File: tb/test_pulse3_timer.sv
module test_pulse3_timer;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       trig = 1'b0;
   logic       pulse_out;
   logic [1:0] state_dbg;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   typedef struct packed {
      logic [1:0] st;
      logic       x;
      logic [2:0] tag;   // 1:R1 3:R3 4:R4 5:R5 0:R8
   } exp_t;

   exp_t       sb_q[$];
   logic [1:0] model_st = 2'b00;
   int         hi_run = 0;

   always #10 clk = ~clk;   // 50 MHz

   pulse3_timer i_pulse3_timer (
      .clk      (clk),
      .rst      (rst),
      .trig     (trig),
      .pulse_out(pulse_out),
      .state_dbg(state_dbg)
   );

   function automatic string tag_name(input logic [2:0] t);
      case (t)
         3'd1:    return "R1";
         3'd3:    return "R3";
         3'd4:    return "R4";
         3'd5:    return "R5";
         default: return "R8";
      endcase
   endfunction

   // Driver: applies one cycle of stimulus on the falling edge and queues the result
   // the reference chain expects after the next rising edge.
   task automatic drive(input logic r, input logic t);
      exp_t e;
      @(negedge clk);
      rst  = r;
      trig = t;
      if (r) begin
         model_st = 2'b00; e.tag = 3'd1;
      end else begin
         case (model_st)
            2'b00: begin e.tag = t ? 3'd4 : 3'd3; model_st = t ? 2'b01 : 2'b00; end
            2'b01: begin e.tag = 3'd5; model_st = 2'b10; end
            2'b10: begin e.tag = 3'd5; model_st = 2'b11; end
            default: begin e.tag = 3'd0; model_st = 2'b00; end
         endcase
      end
      e.st = model_st;
      e.x  = (model_st != 2'b00);
      sb_q.push_back(e);
   endtask

   // Monitor: samples 5 ns after each rising edge and compares with the queue head.
   always @(posedge clk) begin
      #5;
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         n_checks++;
         if (state_dbg !== e.st) begin
            n_fail++;
            $display("FAIL %s/R2: state_dbg=%b expected %b", tag_name(e.tag), state_dbg, e.st);
         end
         n_checks++;
         if (pulse_out !== e.x) begin
            n_fail++;
            $display("FAIL R6: pulse_out=%b expected %b", pulse_out, e.x);
         end
         // R7: every run of high output is exactly three cycles long.
         if (e.tag == 3'd1) hi_run = 0;
         else if (pulse_out === 1'b1) hi_run++;
         else begin
            if (hi_run != 0) begin
               n_checks++;
               if (hi_run != 3) begin
                  n_fail++;
                  $display("FAIL R7: pulse length=%0d expected 3", hi_run);
               end
            end
            hi_run = 0;
         end
      end
   end

   initial begin : watchdog
      #(20 * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run hung, actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] lfsr;
      lfsr = 8'hA5;
      // R1: reset state
      for (int i = 0; i < 4; i++) drive(1'b1, 1'b0);
      // R3: idle with trigger low
      for (int i = 0; i < 5; i++) drive(1'b0, 1'b0);
      // R4/R5/R7: single-cycle trigger
      drive(1'b0, 1'b1);
      for (int i = 0; i < 6; i++) drive(1'b0, 1'b0);
      // R7/R8: trigger held high across pulses
      for (int i = 0; i < 12; i++) drive(1'b0, 1'b1);
      drive(1'b0, 1'b0);
      drive(1'b0, 1'b0);
      // R7: retrigger during the pulse is ignored
      drive(1'b0, 1'b1);
      drive(1'b0, 1'b0);
      drive(1'b0, 1'b1);
      drive(1'b0, 1'b1);
      drive(1'b0, 1'b0);
      for (int i = 0; i < 4; i++) drive(1'b0, 1'b0);
      // R1: reset in the middle of a pulse
      drive(1'b0, 1'b1);
      drive(1'b0, 1'b0);
      drive(1'b1, 1'b1);
      for (int i = 0; i < 4; i++) drive(1'b0, 1'b0);
      // Pseudo-random trigger pattern against the reference chain
      for (int i = 0; i < 300; i++) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         drive(1'b0, lfsr[0] & lfsr[2]);
      end
      for (int i = 0; i < 6; i++) drive(1'b0, 1'b0);
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule